// File: doc/BRIEF.md
# Full-Cycle SPI Host Controller

This block is a single-lane SPI host that gives every serial bit a whole SCK period in each direction. Half-cycle SPI modes 0 and 3 give a bit only half a period. The host drives MOSI on rising SCK edges, and the target takes each bit in on the rising edge that follows. The target drives MISO on falling edges, and the host latches each bit on the next falling edge, one full period after the bit was launched. Because of this the target's clock-to-output time can approach the whole SCK period, and the serial clock can run faster than a mode 0/3 link allows.

SCK is the system clock divided by an even divisor that is sampled when a transfer starts. The system side works on bytes. `start_i` opens a frame with the first byte. The host samples each further byte when it launches bit 8 of the byte before it, and it pulses `tx_next_o` each time it has taken a byte. `last_i`, sampled together with that byte, ends the frame after that byte. Every eight MISO bits the host returns a received byte with a one-cycle valid strobe. Bytes received while the host sends command bytes are reported too, and user logic discards them. Each frame ends with one extra flush pulse, so the target can take in the final MOSI bit.

Top module: `fcspi_host`

## Requirements
- R1: After reset, and while idle, `cs_n_o` is 1, `sck_o` is 0, `busy_o` is 0 and `rx_valid_o` is 0.
- R2: While a frame runs, every SCK high phase and every low phase between pulses lasts div/2 system clocks. div is the value of `div_i` sampled with `start_i`. A change to `div_i` during a frame has no effect.
- R3: `cs_n_o` goes low at least one system clock before the first rising SCK edge. SCK is never high while `cs_n_o` is 1.
- R4: MOSI carries the bytes MSB first. It changes only on the system clock where SCK rises. Bit k of the frame is launched on rising edge k, and a target sampling on rising edge k+1 receives every byte intact.
- R5: MISO is sampled on falling SCK edges. The bit launched by the target on falling edge k-1 (bit 1 at the falling edge of `cs_n_o`) is captured on falling edge k. Received bytes are assembled MSB first.
- R6: Bytes follow back to back with no gap. `tx_next_o` pulses once when the host takes a byte, so once per byte. A frame of N bytes has exactly 8N+1 SCK pulses.
- R7: `rx_valid_o` is a one-cycle pulse with the byte on `rx_data_o`, after every eighth capture. A frame of N bytes gives N pulses, command bytes included.
- R8: `cs_n_o` returns high only after the falling edge of the final (flush) pulse, with SCK low. `busy_o` is high for the whole time `cs_n_o` is low.
- R9: `start_i` while `busy_o` is high is ignored. The running frame keeps its bytes, its pulse count and its SCK timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCK divisor (even, 2 or more), sampled at start |
| start_i | input | 1 | Opens a frame with tx_data_i as first byte |
| tx_data_i | input | BYTE_W | Byte to transmit |
| last_i | input | 1 | Marks the byte being sampled as the frame's last |
| tx_next_o | output | 1 | One-cycle pulse: byte taken, present the next one |
| busy_o | output | 1 | Frame in progress |
| rx_data_o | output | BYTE_W | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| sck_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to target |
| miso_i | input | 1 | Serial data from target |

## Verification
The bench uses the default BYTE_W=8 and DIV_W=8 and varies the divisor at run time between 2 and 10. Divisor 2 makes the rise and fall strobes arrive on adjacent system clocks, which is the tightest case for loading the next byte and capturing a bit. The bench's target model drives MISO three quarters of an SCK period after each falling edge. A host that captured on the rising edge, as mode 0/3 does, would therefore read stale bits and misalign every received byte. Frames of one to six bytes, with all-zero and all-one patterns, check byte alignment in both directions. A start and a divisor change injected during a frame check that both are ignored.

// File: rtl/fcspi_pkg.sv
package fcspi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_END  = 2'd2
  } fcspi_state_e;
endpackage

// File: rtl/fcspi_sck_gen.sv
module fcspi_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tc;

  assign tc     = (cnt_q == half_i - 1'b1);
  assign rise_o = en_i & tc & ~sck_q;
  assign fall_o = en_i & tc & sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tc) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fcspi_tx_path.sv
module fcspi_tx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rise_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              mosi_o,
  output logic              take_o,
  output logic              done_o
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sr_q;
  logic [CW-1:0]     bcnt_q;
  logic              last_q, done_q, mosi_q, take_q;
  logic              launch, end_byte;

  assign launch   = rise_i & ~done_q;
  assign end_byte = launch & (bcnt_q == CW'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      mosi_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      take_q <= load_i | (end_byte & ~last_q);
      if (load_i) begin
        sr_q   <= data_i;
        last_q <= last_i;
        bcnt_q <= '0;
        done_q <= 1'b0;
      end else if (launch) begin
        mosi_q <= sr_q[BYTE_W-1];   // R4: MOSI moves only with a rise strobe
        if (end_byte) begin
          bcnt_q <= '0;
          if (last_q) begin
            done_q <= 1'b1;
          end else begin
            sr_q   <= data_i;        // R6: next byte ready for the following rise
            last_q <= last_i;
          end
        end else begin
          sr_q   <= sr_q << 1;
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign mosi_o = mosi_q;
  assign take_o = take_q;
  assign done_o = done_q;
endmodule

// File: rtl/fcspi_rx_path.sv
module fcspi_rx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              miso_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sr_q, data_q;
  logic [CW-1:0]     bcnt_q;
  logic              valid_q;
  logic [BYTE_W-1:0] sr_nxt;

  assign sr_nxt = {sr_q[BYTE_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      data_q  <= '0;
      bcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clr_i) begin
        bcnt_q <= '0;
      end else if (cap_i) begin  // R5: falling-edge capture
        sr_q <= sr_nxt;
        if (bcnt_q == CW'(BYTE_W - 1)) begin
          bcnt_q  <= '0;
          data_q  <= sr_nxt;
          valid_q <= 1'b1;       // R7
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fcspi_host.sv
module fcspi_host
  import fcspi_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              last_i,
  output logic              tx_next_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  fcspi_state_e     state_q;
  logic [DIV_W-1:0] half_q;
  logic             cs_n_q, flush_q;
  logic             go, rise, fall, tx_done;

  assign go = start_i & (state_q == ST_IDLE);  // R9

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= DIV_W'(1);
      cs_n_q  <= 1'b1;
      flush_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_RUN;
          cs_n_q  <= 1'b0;
          flush_q <= 1'b0;
          // R2: divisor frozen for the frame, floor of half is 1
          half_q  <= (div_i[DIV_W-1:1] == '0) ? DIV_W'(1) : (div_i >> 1);
        end
        ST_RUN: begin
          if (rise && tx_done) flush_q <= 1'b1;
          if (fall && flush_q) state_q <= ST_END;
        end
        ST_END: begin
          state_q <= ST_IDLE;
          cs_n_q  <= 1'b1;             // R8
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fcspi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_RUN),
    .half_i (half_q),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  fcspi_tx_path #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .rise_i (rise),
    .data_i (tx_data_i),
    .last_i (last_i),
    .mosi_o (mosi_o),
    .take_o (tx_next_o),
    .done_o (tx_done)
  );

  fcspi_rx_path #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go),
    .cap_i   (fall & ~flush_q),
    .miso_i  (miso_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

  assign cs_n_o = cs_n_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/fcspi_host_chk.sv
module fcspi_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic busy_o,
  input logic rx_valid_o
);
  AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o); // R3

  AST_CS_LEADS_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> (!cs_n_o && $past(!cs_n_o))); // R3

  AST_MOSI_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> $rose(sck_o)); // R4

  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R7

  AST_BUSY_COVERS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> busy_o); // R8

  AST_CS_RELEASE_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (!sck_o && $past(!sck_o))); // R8
endmodule

bind fcspi_host fcspi_host_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_o      (sck_o),
  .cs_n_o     (cs_n_o),
  .mosi_o     (mosi_o),
  .busy_o     (busy_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/fcspi_host_tb.sv
`timescale 1ns/1ps
module fcspi_host_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd4;
  logic       start_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       last_i = 1'b0;
  logic       tx_next_o, busy_o, rx_valid_o, sck_o, cs_n_o, mosi_o;
  logic [7:0] rx_data_o;
  logic       miso_i = 1'b0;

  always #2 clk = ~clk;

  fcspi_host u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .start_i(start_i),
    .tx_data_i(tx_data_i), .last_i(last_i), .tx_next_o(tx_next_o),
    .busy_o(busy_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int errors = 0, checks = 0;
  logic [7:0] tx_b [8];
  logic [7:0] resp_b [8];
  logic [7:0] rx_got [8];
  logic [7:0] tgt_got [8];
  int n_cur, half_cur, dly;
  int rises_t, falls_t, tgt_bits, rx_cnt, next_p, run, lead;
  int bad_width, bad_mosi, bad_rxv, bad_idle, bad_lead, bad_busy;
  bit lead_seen;
  logic [7:0] tgt_sr;
  logic sck_prev = 1'b0, cs_prev = 1'b1, mosi_prev = 1'b0, rxv_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic resp_bit(input int i);
    return resp_b[i/8][7 - (i%8)];
  endfunction

  // one system clock: sample away from the edge, run target model and monitors
  task automatic tick();
    logic rise, fall;
    @(negedge clk);
    rise = sck_o & !sck_prev;
    fall = !sck_o & sck_prev;
    if (cs_prev && !cs_n_o) begin
      rises_t = 0; falls_t = 0; tgt_bits = 0; lead = 0; lead_seen = 0;
      miso_i = resp_bit(0);
    end
    if (cs_n_o && sck_o) bad_idle++;
    if (!cs_n_o && !busy_o) bad_busy++;
    if (mosi_o !== mosi_prev && !rise) bad_mosi++;
    if (rise || fall) begin
      if (fall && run != half_cur) bad_width++;
      if (rise && rises_t >= 1 && run != half_cur) bad_width++;
      run = 1;
    end else run++;
    if (!cs_n_o) begin
      if (rise) begin
        if (!lead_seen) begin
          lead_seen = 1;
          if (lead < 1) bad_lead++;
        end
        rises_t++;
        if (rises_t >= 2 && tgt_bits < 8*n_cur) begin
          tgt_sr = {tgt_sr[6:0], mosi_prev};
          tgt_bits++;
          if (tgt_bits % 8 == 0) tgt_got[tgt_bits/8 - 1] = tgt_sr;
        end
      end else if (!lead_seen) lead++;
      if (fall) begin
        falls_t++;
        if (falls_t < 8*n_cur) miso_i <= #(dly) resp_bit(falls_t);
      end
    end
    if (tx_next_o) begin
      next_p++;
      if (next_p < n_cur) begin
        tx_data_i = tx_b[next_p];
        last_i = (next_p == n_cur - 1);
      end
    end
    if (rx_valid_o) begin
      if (rxv_prev) bad_rxv++;
      if (rx_cnt < 8) rx_got[rx_cnt] = rx_data_o;
      rx_cnt++;
    end
    sck_prev = sck_o; cs_prev = cs_n_o; mosi_prev = mosi_o; rxv_prev = rx_valid_o;
  endtask

  task automatic run_frame(input int n, input int div, input bit inject);
    int guard;
    n_cur = n; half_cur = div/2; dly = div*3 - 2;
    bad_width = 0; bad_mosi = 0; bad_rxv = 0; bad_idle = 0; bad_lead = 0; bad_busy = 0;
    rx_cnt = 0; next_p = 0; run = 0; rises_t = 0; falls_t = 0;
    div_i = 8'(div);
    start_i = 1'b1; tx_data_i = tx_b[0]; last_i = (n == 1);
    tick();
    start_i = 1'b0;
    guard = 0;
    while (busy_o && guard < 4000) begin
      tick();
      guard++;
      if (inject && guard == 40) begin
        start_i = 1'b1; div_i = 8'd2;   // R9/R2: must be ignored mid-frame
      end else start_i = 1'b0;
    end
    chk(guard < 4000, "watchdog frame", guard, 4000);
    for (int i = 0; i < n; i++) begin
      chk(rx_got[i] == resp_b[i], "R5 rx byte", rx_got[i], resp_b[i]);
      chk(tgt_got[i] == tx_b[i], "R4 target byte", tgt_got[i], tx_b[i]);
    end
    chk(rises_t == 8*n + 1, "R6 pulse count", rises_t, 8*n + 1);
    chk(next_p == n, "R6 tx_next count", next_p, n);
    chk(rx_cnt == n, "R7 rx_valid count", rx_cnt, n);
    chk(bad_rxv == 0, "R7 rx_valid width", bad_rxv, 0);
    chk(bad_width == 0, inject ? "R9 R2 sck phase" : "R2 sck phase", bad_width, 0);
    chk(bad_lead == 0 && bad_idle == 0, "R3 cs framing", bad_lead + bad_idle, 0);
    chk(bad_mosi == 0, "R4 mosi edge", bad_mosi, 0);
    chk(cs_n_o && !sck_o && bad_busy == 0, "R8 release", bad_busy, 0);
    tick(); tick();
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1 && sck_o == 0 && busy_o == 0 && rx_valid_o == 0, "R1 reset",
        {cs_n_o, sck_o, busy_o, rx_valid_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(cs_n_o == 1 && sck_o == 0 && busy_o == 0, "R1 idle",
        {cs_n_o, sck_o, busy_o}, 3'b100);
    // directed corners
    tx_b[0] = 8'hA5; resp_b[0] = 8'h3C;
    run_frame(1, 2, 0);
    tx_b[0] = 8'h00; tx_b[1] = 8'hFF; resp_b[0] = 8'hFF; resp_b[1] = 8'h00;
    run_frame(2, 2, 0);
    for (int i = 0; i < 4; i++) begin tx_b[i] = 8'(8'h81 + i*17); resp_b[i] = 8'(8'h5A ^ i*33); end
    run_frame(4, 8, 1);
    // random frames
    for (int f = 0; f < 20; f++) begin
      int n, d;
      n = 1 + int'($urandom_range(5));
      d = 2 * (1 + int'($urandom_range(4)));
      for (int i = 0; i < n; i++) begin
        tx_b[i] = 8'($urandom); resp_b[i] = 8'($urandom);
      end
      run_frame(n, d, (f % 5) == 4);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule